// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block walks a circular ring of 32-byte transmit descriptors kept in system memory and turns each one into a frame on a byte-wide valid/ready stream. Software fills a descriptor with a buffer address, a length, a destination port map and checksum request bits. It then passes the slot to hardware by clearing the slot's ownership bit. The engine reads the descriptor and the buffer through one 32-bit word memory port. It streams the buffer bytes out, writes the control word back with ownership returned to software, and can pulse an interrupt.

The ring has no programmed length. A per-descriptor end-of-ring bit sends the engine back to the ring base, and any other slot is followed by the next 32-byte slot. A poll enable and a suspend input gate the start of each new descriptor. A pointer-load strobe copies the ring base into the current-descriptor pointer. When the engine finds a slot that software still owns, it waits a fixed number of idle cycles and reads that slot again.

Top module: `txr_dma`

## Requirements
- R1: While reset is held, `out_valid`, `mem_rd_en`, `mem_wr_en` and `irq` are all 0.
- R2: Bit 31 of the control word (byte offset 4 in the slot) is the ownership bit. A value of 0 hands the slot to hardware. A slot read with the bit at 1 produces no output. The engine reads the control word of that same slot again, and successive reads are IDLE_GAP+3 cycles apart.
- R3: A slot with length L (control bits 15:0) and buffer address A (offset 0) emits exactly L bytes. The bytes are read in little-endian order from byte addresses A to A+L-1, and A may have any alignment.
- R4: `out_last` is 1 on the final byte of a frame only when control bit 28 is set. It is 0 on every other byte.
- R5: On every byte, `out_portmap` carries bits 21:17 of the word at offset 8. `out_csum` carries control bits 18:16 (bit 0 TCP, bit 1 UDP, bit 2 IP).
- R6: After the final byte has been accepted, and not earlier, the engine writes the control word back to offset 4 with bit 31 set and all other bits unchanged. Exactly one write is made per descriptor.
- R7: When control bit 27 is set, `irq` is high for exactly one cycle, in the cycle right after the write-back. Otherwise `irq` stays low.
- R8: After a slot whose control bit 30 is set, the next slot read is the ring base. Otherwise the next slot is the current address plus 32.
- R9: With `poll_en` low or `suspend` high, no new descriptor is started. A frame already in progress still runs to its write-back.
- R10: `ptr_load` loads the current-descriptor pointer from `ring_base` when the engine is between descriptors. The next slot read is then the one at the base.
- R11: A hardware-owned slot with length 0 emits no bytes but is still written back, and raises `irq` if control bit 27 is set.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of the first ring slot |
| ptr_load | input | 1 | Copy `ring_base` into the descriptor pointer |
| poll_en | input | 1 | Allow the engine to start descriptors |
| suspend | input | 1 | Hold the engine at the next descriptor boundary |
| mem_rd_en | output | 1 | Word read request; data is expected on `mem_rdata` in the following cycle |
| mem_wr_en | output | 1 | Word write request |
| mem_addr | output | ADDR_W | Word-aligned byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame that ends a packet |
| out_portmap | output | 5 | Destination port map of the current frame |
| out_csum | output | 3 | Checksum offload requests of the current frame |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after unaligned buffers that cross word boundaries. An engine that got these wrong would repeat or skip a byte at each lane wrap. It sends frames with and without the last-segment bit, which catches a last flag raised on every frame end. It uses a zero-length slot, where a wrong design would emit a stray byte or leave the slot owned. End-of-ring wrapping and pointer reload are checked through the address of the next control read, so an engine that ran past the ring or ignored the base would read the wrong slot. Poll enable is dropped in the middle of a frame, and suspend is raised while descriptors are pending. A design that aborted the frame, or kept starting descriptors while held, would show missing bytes or unexpected bytes and write-backs.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int WORD_W     = 32;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int LEN_W      = 16;
   localparam int PMAP_W     = 5;
   localparam int CSUM_W     = 3;

   // control word bit positions (software and hardware both decode these)
   localparam int CTL_CSUM_LSB = 16;
   localparam int CTL_IRQ      = 27;
   localparam int CTL_LAST     = 28;
   localparam int CTL_EOR      = 30;
   localparam int CTL_OWN      = 31;
   // port/tag word
   localparam int TAG_PMAP_LSB = 17;

   // byte offsets of the words inside a slot
   localparam int OFS_BUF = 0;
   localparam int OFS_CTL = 4;
   localparam int OFS_TAG = 8;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_CTL,
      S_WT_CTL,
      S_GAP,
      S_RD_BUF,
      S_WT_BUF,
      S_RD_TAG,
      S_WT_TAG,
      S_RD_DAT,
      S_WT_DAT,
      S_SEND,
      S_WB
   } txr_state_e;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
   parameter int ADDR_W     = 32,
   parameter int DESC_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base,
   input  logic              load,
   input  logic              advance,
   input  logic              wrap,
   output logic [ADDR_W-1:0] cur
);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DESC_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN = ~(STEP - ADDR_W'(1));

   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] base_al;

   assign base_al = base & ALIGN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (load) begin
         cur_q <= base_al;
      end else if (advance) begin
         cur_q <= wrap ? base_al : (cur_q + STEP);
      end
   end

   assign cur = cur_q;
endmodule

// File: rtl/txr_gap_timer.sv
module txr_gap_timer #(
   parameter int GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int GAP_M1 = (GAP <= 1) ? 0 : GAP - 1;
   localparam int CNT_W  = (GAP_M1 < 1) ? 1 : $clog2(GAP_M1 + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_M1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || done) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane #(
   parameter int WORD_BYTES = 4,
   localparam int SEL_W = (WORD_BYTES < 2) ? 1 : $clog2(WORD_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [8*WORD_BYTES-1:0] din,
   input  logic [SEL_W-1:0]        sel,
   output logic [7:0]              dout
);
   logic [8*WORD_BYTES-1:0] word_q;
   logic [7:0]              lanes [WORD_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load) begin
         word_q <= din;
      end
   end

   // little-endian lane split: lane g holds the byte at address offset g
   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign lanes[g] = word_q[8*g +: 8];
   end

   assign dout = lanes[sel];
endmodule

// File: rtl/txr_dma.sv
module txr_dma
   import txr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DESC_BYTES = 32,
   parameter int IDLE_GAP   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              ptr_load,
   input  logic              poll_en,
   input  logic              suspend,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic [4:0]        out_portmap,
   output logic [2:0]        out_csum,
   output logic              irq
);
   localparam int SEL_W = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_BUF = ADDR_W'(OFS_BUF);
   localparam logic [ADDR_W-1:0] A_TAG = ADDR_W'(OFS_TAG);
   localparam logic [LEN_W-1:0]  ONE   = LEN_W'(1);

   // elaboration-time parameter checks
   if (DESC_BYTES < 16 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_desc
      $error("DESC_BYTES must be a power of two of at least 16");
   end
   if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and 32");
   end
   if (IDLE_GAP < 0) begin : g_bad_gap
      $error("IDLE_GAP must not be negative");
   end

   txr_state_e        st_q, st_nxt;
   logic [WORD_W-1:0] ctl_q;
   logic [ADDR_W-1:0] bufp_q;
   logic [PMAP_W-1:0] pmap_q;
   logic [LEN_W-1:0]  remain_q;
   logic              irq_q;
   logic [ADDR_W-1:0] cur;
   logic              fire;
   logic              at_boundary;
   logic              gap_done;
   logic              lane_end;

   assign at_boundary = (st_q == S_IDLE) || (st_q == S_GAP);
   assign fire        = out_valid && out_ready;
   assign lane_end    = &bufp_q[SEL_W-1:0];

   txr_ring_ptr #(
      .ADDR_W     (ADDR_W),
      .DESC_BYTES (DESC_BYTES)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .base    (ring_base),
      .load    (ptr_load && at_boundary),
      .advance (st_q == S_WB),
      .wrap    (ctl_q[CTL_EOR]),
      .cur     (cur)
   );

   txr_gap_timer #(
      .GAP (IDLE_GAP)
   ) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == S_GAP),
      .done  (gap_done)
   );

   txr_byte_lane #(
      .WORD_BYTES (WORD_BYTES)
   ) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (st_q == S_WT_DAT),
      .din   (mem_rdata),
      .sel   (bufp_q[SEL_W-1:0]),
      .dout  (out_data)
   );

   // memory port requests, one per state
   always_comb begin
      mem_rd_en = 1'b0;
      mem_wr_en = 1'b0;
      mem_addr  = cur;
      mem_wdata = {1'b1, ctl_q[CTL_OWN-1:0]};
      unique case (st_q)
         S_RD_CTL: begin
            mem_rd_en = 1'b1;
            mem_addr  = cur + A_CTL;
         end
         S_RD_BUF: begin
            mem_rd_en = 1'b1;
            mem_addr  = cur + A_BUF;
         end
         S_RD_TAG: begin
            mem_rd_en = 1'b1;
            mem_addr  = cur + A_TAG;
         end
         S_RD_DAT: begin
            mem_rd_en = 1'b1;
            mem_addr  = {bufp_q[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
         end
         S_WB: begin
            mem_wr_en = 1'b1;
            mem_addr  = cur + A_CTL;
         end
         default: ;
      endcase
   end

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         S_IDLE:   if (poll_en && !suspend) st_nxt = S_RD_CTL;
         S_RD_CTL: st_nxt = S_WT_CTL;
         S_WT_CTL: st_nxt = mem_rdata[CTL_OWN] ? S_GAP : S_RD_BUF;
         S_GAP:    if (gap_done) st_nxt = S_IDLE;
         S_RD_BUF: st_nxt = S_WT_BUF;
         S_WT_BUF: st_nxt = S_RD_TAG;
         S_RD_TAG: st_nxt = S_WT_TAG;
         S_WT_TAG: st_nxt = (ctl_q[LEN_W-1:0] == '0) ? S_WB : S_RD_DAT;
         S_RD_DAT: st_nxt = S_WT_DAT;
         S_WT_DAT: st_nxt = S_SEND;
         S_SEND: begin
            if (fire) begin
               if (remain_q == ONE) st_nxt = S_WB;
               else if (lane_end)   st_nxt = S_RD_DAT;
            end
         end
         S_WB:     st_nxt = S_IDLE;
         default:  st_nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         ctl_q    <= '0;
         bufp_q   <= '0;
         pmap_q   <= '0;
         remain_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         st_q  <= st_nxt;
         irq_q <= (st_q == S_WB) && ctl_q[CTL_IRQ];
         if (st_q == S_WT_CTL && !mem_rdata[CTL_OWN]) ctl_q <= mem_rdata;
         if (st_q == S_WT_BUF) bufp_q <= ADDR_W'(mem_rdata);
         if (st_q == S_WT_TAG) remain_q <= ctl_q[LEN_W-1:0];
         if (st_q == S_RD_TAG) pmap_q <= '0;
         if (st_q == S_WT_BUF) pmap_q <= pmap_q;
         if (st_q == S_WT_TAG) pmap_q <= mem_rdata[TAG_PMAP_LSB +: PMAP_W];
         if (fire) begin
            bufp_q   <= bufp_q + ADDR_W'(1);
            remain_q <= remain_q - ONE;
         end
      end
   end

   assign out_valid   = (st_q == S_SEND);
   assign out_last    = out_valid && (remain_q == ONE) && ctl_q[CTL_LAST];
   assign out_portmap = pmap_q;
   assign out_csum    = ctl_q[CTL_CSUM_LSB +: CSUM_W];
   assign irq         = irq_q;
endmodule

// File: rtl/txr_dma_chk.sv
module txr_dma_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_data,
   input logic              out_last,
   input logic [4:0]        out_portmap,
   input logic [2:0]        out_csum,
   input logic              irq
);
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   p_tag_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |=> $stable(out_portmap) && $stable(out_csum));

   p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   p_irq_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(mem_wr_en));

   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_quiet_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !mem_rd_en && !mem_wr_en);

   p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en || mem_wr_en) |-> mem_addr[1:0] == 2'b00);

   p_wb_after_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> !out_valid);
endmodule

bind txr_dma txr_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_rd_en   (mem_rd_en),
   .mem_wr_en   (mem_wr_en),
   .mem_addr    (mem_addr),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_data    (out_data),
   .out_last    (out_last),
   .out_portmap (out_portmap),
   .out_csum    (out_csum),
   .irq         (irq)
);

// File: tb/tb_txr_dma.sv
`timescale 1ns/1ps
module tb_txr_dma;
   localparam int GAP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ring_base = 32'h0;
   logic        ptr_load = 1'b0;
   logic        poll_en = 1'b0;
   logic        suspend = 1'b0;
   logic        mem_rd_en, mem_wr_en;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = 32'h0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;
   logic        out_last;
   logic [4:0]  out_portmap;
   logic [2:0]  out_csum;
   logic        irq;

   always #4 clk = ~clk;

   txr_dma #(.ADDR_W(32), .DESC_BYTES(32), .IDLE_GAP(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ptr_load(ptr_load),
      .poll_en(poll_en), .suspend(suspend), .mem_rd_en(mem_rd_en),
      .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .out_portmap(out_portmap),
      .out_csum(out_csum), .irq(irq));

   logic [31:0] mem [0:1023];
   int checks = 0, errors = 0, cyc = 0, rmode = 0;
   bit done = 1'b0;
   logic [16:0] bq[$];
   logic [31:0] wa_q[$], wd_q[$];
   int wc_q[$];
   int bytes_acc = 0, bytes_pushed = 0, wr_cnt = 0, irq_cnt = 0, irq_exp = 0;
   int last_ctl_cyc = -1, last_period = 0;
   logic [31:0] last_ctl_addr = 32'h0;
   bit prev_wr = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rd_byte(input int a);
      return mem[a >> 2][(a % 4) * 8 +: 8];
   endfunction

   // reference model: memory, ready pattern, and transaction comparison
   always @(negedge clk) begin
      logic [16:0] e;
      cyc++;
      out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (rst_n) begin
         if (out_valid && out_ready) begin
            if (bq.size() == 0) begin
               chk(1'b0, "R9 unexpected byte", {24'h0, out_data}, 32'h0);
            end else begin
               e = bq.pop_front();
               chk(out_data == e[7:0], "R3 data", {24'h0, out_data}, {24'h0, e[7:0]});
               chk(out_last == e[16], "R4 last", {31'h0, out_last}, {31'h0, e[16]});
               chk({out_portmap, out_csum} == e[15:8], "R5 tag", {24'h0, out_portmap, out_csum}, {24'h0, e[15:8]});
            end
            bytes_acc++;
         end
         if (mem_wr_en) begin
            if (wa_q.size() == 0) begin
               chk(1'b0, "R6 unexpected write", mem_addr, 32'h0);
            end else begin
               chk(mem_addr == wa_q.pop_front(), "R6 addr", mem_addr, 32'h0);
               chk(mem_wdata == wd_q.pop_front(), "R6 data", mem_wdata, 32'h0);
               chk(bytes_acc == wc_q.pop_front(), "R6 order", bytes_acc, 32'h0);
            end
            mem[mem_addr[11:2]] = mem_wdata;
            wr_cnt++;
         end
         if (mem_rd_en) begin
            mem_rdata = mem[mem_addr[11:2]];
            if (mem_addr >= 32'h100 && mem_addr < 32'h200 && mem_addr[4:0] == 5'd4) begin
               if (last_ctl_cyc >= 0) last_period = cyc - last_ctl_cyc;
               last_ctl_cyc = cyc;
               last_ctl_addr = mem_addr;
            end
         end
         if (irq) begin
            irq_cnt++;
            chk(prev_wr, "R7 irq without write-back", 32'h0, 32'h1);
         end
         prev_wr = mem_wr_en;
      end
   end

   task automatic push_desc(input int d);
      logic [31:0] c, b, t;
      int len;
      c = mem[d/4 + 1]; b = mem[d/4]; t = mem[d/4 + 2];
      len = int'(c[15:0]);
      for (int i = 0; i < len; i++)
         bq.push_back({(i == len - 1) && c[28], t[21:17], c[18:16], rd_byte(int'(b) + i)});
      bytes_pushed += len;
      wa_q.push_back(32'(d + 4));
      wd_q.push_back(c | 32'h8000_0000);
      wc_q.push_back(bytes_pushed);
      if (c[27]) irq_exp++;
   endtask

   task automatic arm(input int d, input int b, input int len, input logic [2:0] cs,
                      input bit irqb, input bit last, input bit eor, input logic [4:0] pm, input bit expect_it);
      mem[d/4] = 32'(b);
      mem[d/4 + 2] = {10'h0, pm, 17'h0};
      mem[d/4 + 1] = {1'b0, eor, 1'b1, last, irqb, 8'h0, cs, 16'(len)};
      if (expect_it) push_desc(d);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic drain(input string req);
      int t = 0;
      while ((bq.size() != 0 || wa_q.size() != 0) && t < 3000) begin
         step(1);
         t++;
      end
      chk(t < 3000, req, t, 32'd3000);
      step(5);
   endtask

   initial begin
      int b0, w0;
      for (int i = 0; i < 1024; i++)
         mem[i] = (i >= 256 && i < 512) ? {8'(i*4*7+24), 8'(i*4*7+17), 8'(i*4*7+10), 8'(i*4*7+3)} : 32'h8000_0000;
      step(2);
      // R1: quiet outputs while reset held
      chk(!out_valid && !mem_rd_en && !mem_wr_en && !irq, "R1 reset",
          {28'h0, out_valid, mem_rd_en, mem_wr_en, irq}, 32'h0);
      step(3);
      rst_n = 1'b1;
      step(3);

      // R3 R4 R5 R8 R11: three slots, last one zero-length with wrap
      ring_base = 32'h100;
      ptr_load = 1'b1; step(1); ptr_load = 1'b0;
      arm(32'h100, 32'h400, 5, 3'b001, 1, 1, 0, 5'h01, 1);
      arm(32'h120, 32'h503, 7, 3'b110, 0, 0, 0, 5'h10, 1);
      arm(32'h140, 32'h5F0, 0, 3'b000, 1, 1, 1, 5'h04, 1);
      poll_en = 1'b1;
      drain("R3 drain");
      step(45);
      chk(irq_cnt == irq_exp, "R7 irq count", irq_cnt, irq_exp);
      chk(last_ctl_addr == 32'h104, "R8 wrap to base", last_ctl_addr, 32'h104);
      chk(last_period == GAP + 3, "R2 poll period", last_period, GAP + 3);
      chk(bytes_acc == 12, "R2 software-owned slot not sent", bytes_acc, 32'd12);

      // R12: backpressure on a misaligned frame
      rmode = 1;
      b0 = bytes_acc;
      arm(32'h100, 32'h601, 9, 3'b101, 0, 1, 0, 5'h0A, 1);
      drain("R12 drain");
      chk(bytes_acc == b0 + 9, "R12 byte count", bytes_acc, b0 + 9);

      // R9: poll disabled mid-frame, then held by suspend
      b0 = bytes_acc;
      arm(32'h120, 32'h640, 20, 3'b010, 1, 1, 0, 5'h03, 1);
      while (bytes_acc == b0) step(1);
      poll_en = 1'b0;
      drain("R9 frame completes");
      chk(bytes_acc == b0 + 20, "R9 frame complete", bytes_acc, b0 + 20);
      b0 = bytes_acc; w0 = wr_cnt;
      arm(32'h140, 32'h680, 3, 3'b000, 0, 1, 1, 5'h1F, 0);
      step(40);
      chk(bytes_acc == b0 && wr_cnt == w0, "R9 disabled no start", bytes_acc, b0);
      suspend = 1'b1; poll_en = 1'b1;
      step(40);
      chk(bytes_acc == b0 && wr_cnt == w0, "R9 suspended no start", wr_cnt, w0);
      push_desc(32'h140);
      suspend = 1'b0;
      drain("R9 resume");
      step(30);
      chk(last_ctl_addr == 32'h104, "R8 wrap after end-of-ring", last_ctl_addr, 32'h104);

      // R10 R11: pointer reload and a zero-length slot
      rmode = 0;
      poll_en = 1'b0;
      step(20);
      ring_base = 32'h180;
      ptr_load = 1'b1; step(1); ptr_load = 1'b0;
      b0 = bytes_acc; w0 = wr_cnt;
      arm(32'h180, 32'h700, 0, 3'b000, 1, 0, 1, 5'h02, 1);
      poll_en = 1'b1;
      drain("R10 drain");
      step(30);
      chk(bytes_acc == b0, "R11 no bytes", bytes_acc, b0);
      chk(wr_cnt == w0 + 1, "R11 written back", wr_cnt, w0 + 1);
      chk(last_ctl_addr == 32'h184, "R10 reloaded pointer", last_ctl_addr, 32'h184);
      chk(irq_cnt == irq_exp, "R7 irq total", irq_cnt, irq_exp);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule